// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction 32-bit Processor Core

This block is a 32-bit processor core that finishes every instruction in a single clock cycle. It fetches a word from a small word-addressed instruction memory at the program counter. It decodes the word and reads two operands from a 32-entry register file. An ALU computes a sum, a difference or a bitwise OR. The result, or a word read from a word-addressed data memory, is written back on the same clock edge. The PC moves to the next word, to a branch target or to a jump target.

Only seven operations exist: unsigned add, unsigned subtract, OR with an immediate, load word, store word, branch when two registers are equal, and an absolute jump. Any other encoding leaves registers and memory untouched and only steps the PC.

Both memories are filled through a word load port while the core is held in reset. After that the core runs on its own. The register file can be read at any time through a combinational debug port, and the current PC is brought out as a registered output.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. The core writes neither memory during reset.
- R2: With opcode `000000` in bits [31:26], funct `100000` in [5:0] writes rs+rt (mod 2^32) to rd, and funct `100010` writes rs−rt (mod 2^32) to rd. rs is bits [25:21], rt is [20:16] and rd is [15:11].
- R3: Opcode `001101` writes rs OR the zero-extended immediate in bits [15:0] to rt.
- R4: Opcode `100011` writes to rt the data word indexed by bits [DMEM_AW+1:2] of rs plus the sign-extended immediate. Higher address bits are ignored.
- R5: Opcode `101011` writes rt to the data word addressed as in R4 and changes no register.
- R6: Opcode `000100` sets the next PC to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise. No register is written.
- R7: Opcode `000010` sets the next PC to {(PC+4)[31:28], bits [25:0], 00}.
- R8: Register 0 always reads as 0, and a write to it is discarded.
- R9: An undefined opcode, or opcode `000000` with a funct other than the two in R2, writes no register and no memory and advances the PC by 4.
- R10: An instruction that reads and writes the same register reads the value held before its own write.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4. Instructions are fetched from word index PC[IMEM_AW+1:2].
- R12: When `ld_en` is high at a rising edge, `ld_data` is written to instruction word `ld_addr` if `ld_sel` is 0, or to data word `ld_addr` if `ld_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Register value (combinational, 0 for index 0) |
| pc_out | output | 32 | Current program counter |

## Verification
The directed program goes after the places where a core usually slips. If OR-immediate sign-extended, a value of 0xFFFF would turn into all ones. A load with a negative offset would fetch the wrong word if the load sign-extension were missing. A doubling of r1 through `addu r1,r1,r1` shows whether read-before-write holds. A wrong choice of write destination would corrupt rt on a store or on an R-type instruction. A taken branch and a jump over skip slots would leave marker registers set if the next-PC selection were wrong, and undefined encodings would leave them set if they were not treated as no-ops. Random programs, including backward branches and arbitrary jumps, are compared cycle by cycle against a bench instruction model, covering the PC and the register just written.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADDU  = 6'b100000;
  localparam logic [5:0] FN_SUBU  = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // write destination is rd (else rt)
    logic    src_imm;   // ALU operand B is the extended immediate
    logic    wb_mem;    // write-back value comes from data memory
    logic    reg_we;    // register file write
    logic    mem_we;    // data memory write
    logic    is_beq;    // conditional branch
    logic    is_jump;   // absolute jump
    logic    imm_sext;  // sign-extend (else zero-extend) the immediate
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/rcore_decoder.sv
module rcore_decoder
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
             mem_we: 1'b0, is_beq: 1'b0, is_jump: 1'b0, imm_sext: 1'b0,
             alu_op: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.imm_sext = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OP_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.mem_we   = 1'b1;
        ctrl.imm_sext = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.is_beq   = 1'b1;
        ctrl.imm_sext = 1'b1;
        ctrl.alu_op   = ALU_SUB;
      end
      OP_J: begin
        ctrl.is_jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/rcore_wmem.sv
module rcore_wmem #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREGS   = 32,
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  localparam int RAW    = $clog2(NREGS),
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  input  logic [RAW-1:0]   dbg_addr,
  output logic [XLEN-1:0]  dbg_data,
  output logic [XLEN-1:0]  pc_out
);

  localparam int IMMW = 16;
  localparam int JTW  = 26;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  logic [XLEN-1:0] instr;
  logic [5:0]      opcode;
  logic [5:0]      funct;
  logic [RAW-1:0]  rs_a, rt_a, rd_a;
  logic [IMMW-1:0] imm16;
  logic [JTW-1:0]  jtgt;

  ctrl_t           ctrl;

  logic [XLEN-1:0] rs_data, rt_data;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_ext;
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  logic               ld_im, ld_dm;
  logic               dm_we;
  logic [DMEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]    dm_wdata;
  logic [XLEN-1:0]    dm_rdata;

  // Instruction fetch
  assign ld_im = ld_en && !ld_sel;

  rcore_wmem #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk   (clk),
    .we    (ld_im),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  // Field split
  assign opcode = instr[31:26];
  assign rs_a   = instr[25:21];
  assign rt_a   = instr[20:16];
  assign rd_a   = instr[15:11];
  assign funct  = instr[5:0];
  assign imm16  = instr[IMMW-1:0];
  assign jtgt   = instr[JTW-1:0];

  rcore_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  // Register file
  assign rf_we    = ctrl.reg_we && !rst;
  assign rf_waddr = ctrl.dst_rd ? rd_a : rt_a;
  assign rf_wdata = ctrl.wb_mem ? dm_rdata : alu_y;

  rcore_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (rs_a),
    .rd1   (rs_data),
    .ra2   (rt_a),
    .rd2   (rt_data),
    .ra3   (dbg_addr),
    .rd3   (dbg_data)
  );

  // Immediate extension
  assign imm_sx  = {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};
  assign imm_zx  = {{(XLEN-IMMW){1'b0}}, imm16};
  assign imm_ext = ctrl.imm_sext ? imm_sx : imm_zx;

  // Execute
  assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

  rcore_alu #(.W(XLEN)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // Data memory: the load port has priority over a store
  assign ld_dm    = ld_en && ld_sel;
  assign dm_we    = ld_dm || (ctrl.mem_we && !rst);
  assign dm_waddr = ld_dm ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dm_wdata = ld_dm ? ld_data : rt_data;

  rcore_wmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DMEM_AW+1:2]),
    .rdata (dm_rdata)
  );

  // Next PC
  assign pc_plus4   = pc_q + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1:JTW+2], jtgt, 2'b00};

  always_comb begin
    if (ctrl.is_jump)                 pc_next = jmp_target;
    else if (ctrl.is_beq && alu_zero) pc_next = br_target;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_out = pc_q;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
  import rcore_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input ctrl_t       ctrl,
  input logic [4:0]  rs_a,
  input logic [31:0] rs_data,
  input logic        rf_we,
  input logic        dm_we,
  input logic        ld_en,
  input logic        ld_sel
);

  logic        known;
  logic [31:0] pc_inc;

  // Independent view of which encodings are legal
  always_comb begin
    case (instr[31:26])
      6'b000000: known = (instr[5:0] == 6'b100000) || (instr[5:0] == 6'b100010);
      6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b000010: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign pc_inc = pc_q + 32'd4;

  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    (rst && !ld_en) |-> (!dm_we && !rf_we));

  p_store_noreg_r5: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'b101011) |-> !rf_we);

  p_jump_dest_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'b000010) |=>
      (pc_q == {$past(pc_inc[31:28]), $past(instr[25:0]), 2'b00}));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (rs_a == 5'd0) |-> (rs_data == 32'd0));

  p_undef_nop_r9: assert property (@(posedge clk) disable iff (rst)
    (!known && !ld_en) |-> (!rf_we && !dm_we));

  p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
    ((instr[31:26] != 6'b000010) && (instr[31:26] != 6'b000100)) |=>
      (pc_q == $past(pc_q) + 32'd4));

  p_ctrl_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_beq || ctrl.is_jump) |-> (!rf_we && !ctrl.mem_we));

endmodule

bind rcore_top rcore_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc_q    (pc_q),
  .instr   (instr),
  .ctrl    (ctrl),
  .rs_a    (rs_a),
  .rs_data (rs_data),
  .rf_we   (rf_we),
  .dm_we   (dm_we),
  .ld_en   (ld_en),
  .ld_sel  (ld_sel)
);

// File: tb/rcore_top_tb_top.sv
`timescale 1ns/1ps
module rcore_top_tb_top;

  localparam int IAW = 8;
  localparam int DAW = 8;
  localparam int ID  = 1 << IAW;
  localparam int DD  = 1 << DAW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic          ld_sel = 1'b0;
  logic [7:0]    ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [4:0]    dbg_addr = '0;
  logic [31:0]   dbg_data;
  logic [31:0]   pc_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] b_imem [ID];
  logic [31:0] b_dmem [DD];
  logic [31:0] b_reg  [32];
  logic [31:0] b_pc;

  rcore_top #(.IMEM_AW(IAW), .DMEM_AW(DAW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .pc_out   (pc_out)
  );

  always #2.5 clk = ~clk;

  // Encoders
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench instruction model, written from the requirements
  task automatic iss_step(output int wr);
    logic [31:0] ins, a, b, sx, zx, pc4, nxt, val, addr;
    ins = b_imem[b_pc[IAW+1:2]];
    a   = b_reg[ins[25:21]];
    b   = b_reg[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    zx  = {16'd0, ins[15:0]};
    pc4 = b_pc + 32'd4;
    nxt = pc4;
    wr  = -1;
    val = '0;
    case (ins[31:26])
      6'b000000: begin
        if (ins[5:0] == 6'b100000) begin val = a + b; wr = int'(ins[15:11]); end
        else if (ins[5:0] == 6'b100010) begin val = a - b; wr = int'(ins[15:11]); end
      end
      6'b001101: begin val = a | zx; wr = int'(ins[20:16]); end
      6'b100011: begin addr = a + sx; val = b_dmem[addr[DAW+1:2]]; wr = int'(ins[20:16]); end
      6'b101011: begin addr = a + sx; b_dmem[addr[DAW+1:2]] = b; end
      6'b000100: if (a == b) nxt = pc4 + {sx[29:0], 2'b00};
      6'b000010: nxt = {pc4[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    if (wr > 0) b_reg[wr] = val;
    if (wr == 0) wr = -1;
    b_pc = nxt;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_addr = 5'(idx);
    #0.5;
    v = dbg_data;
  endtask

  // Hold reset, load both memories, check reset state, release
  task automatic load_and_start();
    logic [31:0] v;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < ID; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 8'(i); ld_data = b_imem[i];
    end
    for (int i = 0; i < DD; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 8'(i); ld_data = b_dmem[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    chk("R1 pc after reset", pc_out, 32'd0);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      chk("R1 register cleared", v, 32'd0);
    end
    for (int r = 0; r < 32; r++) b_reg[r] = '0;
    b_pc = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cmp(input int cycles);
    int w;
    logic [31:0] v;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      iss_step(w);
      @(negedge clk);
      chk("R11 pc sequence", pc_out, b_pc);
      if (w < 0) w = c % 32;
      read_reg(w, v);
      chk("R2 register state vs model", v, b_reg[w]);
    end
  endtask

  task automatic rand_program();
    for (int i = 0; i < ID; i++) begin
      int k, rs, rt, rd;
      k  = int'($urandom % 9);
      rs = int'($urandom % 8);
      rt = int'($urandom % 8);
      rd = int'($urandom % 8);
      case (k)
        0: b_imem[i] = enc_r(rs, rt, rd, 6'b100000);
        1: b_imem[i] = enc_r(rs, rt, rd, 6'b100010);
        2: b_imem[i] = enc_i(6'b001101, rs, rt, 16'($urandom));
        3: b_imem[i] = enc_i(6'b100011, rs, rt, 16'($urandom));
        4: b_imem[i] = enc_i(6'b101011, rs, rt, 16'($urandom));
        5: b_imem[i] = enc_i(6'b000100, rs, rt, 16'(int'($urandom % 17) - 8));
        6: b_imem[i] = enc_j(26'($urandom % ID));
        7: b_imem[i] = enc_i(6'b111111, rs, rt, 16'($urandom));
        default: b_imem[i] = enc_r(rs, rt, rd, 6'b100100);
      endcase
    end
    for (int i = 0; i < DD; i++) b_dmem[i] = $urandom;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));

    // Random programs against the model
    for (int p = 0; p < 3; p++) begin
      rand_program();
      load_and_start();
      run_cmp(400);
    end

    // Directed program
    for (int i = 0; i < ID; i++) b_imem[i] = enc_j(26'd20);
    for (int i = 0; i < DD; i++) b_dmem[i] = 32'hD000_0000 + 32'(i);
    b_imem[0]  = enc_i(6'b001101, 0, 1, 16'hFFFF);
    b_imem[1]  = enc_i(6'b001101, 0, 2, 16'h8000);
    b_imem[2]  = enc_r(1, 2, 3, 6'b100000);
    b_imem[3]  = enc_r(2, 1, 4, 6'b100010);
    b_imem[4]  = enc_r(1, 1, 1, 6'b100000);
    b_imem[5]  = enc_i(6'b001101, 1, 0, 16'h0007);
    b_imem[6]  = enc_r(0, 1, 5, 6'b100000);
    b_imem[7]  = enc_i(6'b101011, 0, 3, 16'h0008);
    b_imem[8]  = enc_i(6'b100011, 0, 6, 16'h0008);
    b_imem[9]  = enc_i(6'b001101, 0, 7, 16'h0040);
    b_imem[10] = enc_i(6'b100011, 7, 8, 16'hFFFC);
    b_imem[11] = enc_i(6'b000100, 1, 5, 16'h0001);
    b_imem[12] = enc_i(6'b001101, 0, 9, 16'h0001);
    b_imem[13] = enc_i(6'b000100, 1, 0, 16'h0001);
    b_imem[14] = enc_i(6'b001101, 0, 10, 16'h0002);
    b_imem[15] = enc_i(6'b111111, 0, 11, 16'h1234);
    b_imem[16] = enc_r(1, 1, 12, 6'b100100);
    b_imem[17] = enc_j(26'd20);
    b_imem[18] = enc_i(6'b001101, 0, 13, 16'h0003);
    b_imem[19] = enc_i(6'b001101, 0, 13, 16'h0003);
    b_imem[20] = enc_j(26'd20);
    load_and_start();
    run_cmp(30);

    chk("R11 final pc", pc_out, 32'd80);
    read_reg(1, v);  chk("R10 r1 doubled from old value", v, 32'h0001FFFE);
    read_reg(2, v);  chk("R3 ori zero-extends 0x8000", v, 32'h00008000);
    read_reg(3, v);  chk("R2 addu", v, 32'h00017FFF);
    read_reg(4, v);  chk("R2 subu wraps", v, 32'hFFFF8001);
    read_reg(0, v);  chk("R8 r0 write discarded", v, 32'd0);
    read_reg(5, v);  chk("R8 r0 reads zero as source", v, 32'h0001FFFE);
    read_reg(6, v);  chk("R5 stored word loaded back", v, 32'h00017FFF);
    read_reg(7, v);  chk("R3 ori", v, 32'h00000040);
    read_reg(8, v);  chk("R4 negative offset load", v, 32'hD000000F);
    read_reg(9, v);  chk("R6 taken branch skips", v, 32'd0);
    read_reg(10, v); chk("R6 untaken branch falls through", v, 32'd2);
    read_reg(11, v); chk("R9 undefined opcode no write", v, 32'd0);
    read_reg(12, v); chk("R9 undefined funct no write", v, 32'd0);
    read_reg(13, v); chk("R7 jump skips slots", v, 32'd0);

    // Load-port check: program uses data preloaded through the port
    for (int i = 0; i < ID; i++) b_imem[i] = enc_j(26'd2);
    for (int i = 0; i < DD; i++) b_dmem[i] = 32'h5A00_0000 ^ (32'(i) << 4);
    b_imem[0] = enc_i(6'b100011, 0, 14, 16'h03FC);
    b_imem[1] = enc_i(6'b100011, 0, 15, 16'h0004);
    load_and_start();
    run_cmp(6);
    read_reg(14, v); chk("R12 data word 255 loaded", v, 32'h5A000FF0);
    read_reg(15, v); chk("R12 data word 1 loaded", v, 32'h5A000010);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule